// File: doc/BRIEF.md
# Up/Down Wiper Position Controller

This block chooses one tap of a 32-position resistor ladder. It is driven by three slow, asynchronous control pins: an active-low select, a direction level and an active-low step strobe. While the block is selected, each falling edge of the step strobe moves a 5-bit wiper count one position up or down. The count stops at either end and never wraps. The count is decoded into a one-hot tap-select vector that drives the ladder switches.

Releasing select while the step strobe is high saves the count to a modeled nonvolatile register. That register is written only after a programmable delay, and a busy flag stays high for the whole delay. Releasing select while the step strobe is low leaves the register untouched. Once no save is in progress and the block is deselected, a standby flag is raised.

A power-on reset loads the nonvolatile register with a model-level initial value. Both the power-on reset and the soft reset reload the count from that register. The soft reset does not change the register, so the soft reset is also how a saved value is observed.

Top module: `wiper_ctrl`

## Requirements
- R1: `tap_sel` has exactly one bit set, and that bit is at index `wiper_pos`.
- R2: Step strobe edges while `sel_n` is high (deselected) leave `wiper_pos` unchanged.
- R3: In the selected state, a falling edge of `step_n` adds one to `wiper_pos` when `dir_up` is 1 and subtracts one when `dir_up` is 0.
- R4: `wiper_pos` holds at 31 when stepped up and at 0 when stepped down. It never wraps.
- R5: A rising edge of `sel_n` while `step_n` is high starts a save. `store_busy` is then high for exactly `STORE_CYCLES` clock cycles, and the nonvolatile register takes the count when that window ends.
- R6: A rising edge of `sel_n` while `step_n` is low ends the selection without a save, and the nonvolatile register keeps its old value. If the select rise and a step fall are seen in the same cycle, the select rise wins and the count does not move.
- R7: `standby` is high whenever the block is deselected with no save in progress. It falls when `sel_n` goes low, and it is never high together with `store_busy`.
- R8: Step strobe edges that arrive while `store_busy` is high do not change `wiper_pos`.
- R9: A pulse on `rst_n` reloads `wiper_pos` from the nonvolatile register and leaves that register unchanged.
- R10: A pulse on `por_n` sets the nonvolatile register to `NV_INIT`, and `wiper_pos` then equals `NV_INIT`.
- R11: Every control pin passes through a two-flop synchronizer. `wiper_pos` changes on the third rising clock edge after `step_n` falls, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low; initialises the nonvolatile register |
| rst_n | input | 1 | Soft reset, active low; reloads the count from the nonvolatile register |
| sel_n | input | 1 | Select, active low, asynchronous |
| dir_up | input | 1 | Step direction: 1 = up, 0 = down; asynchronous |
| step_n | input | 1 | Step strobe; acts on its falling edge; asynchronous |
| tap_sel | output | TAPS | One-hot ladder tap select |
| wiper_pos | output | $clog2(TAPS) | Current wiper count |
| store_busy | output | 1 | High while a nonvolatile write is pending |
| standby | output | 1 | Deselected and idle |

## Verification
The hardest situation to reach is a step strobe edge that lands inside the save window. The stimulus raises select with the strobe high, waits until the busy flag is seen, then pulls select low and pulses the strobe. All of this finishes several cycles before the write delay ends. A soft reset afterwards shows that the saved value is the count from before the pulse.

The tie case of R6 is reached by changing `step_n` and `sel_n` at the same clock phase, so both land in the same synchronizer cycle. Every save and every aborted save is then checked through the recall that follows a soft reset.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
  typedef enum logic [1:0] {
    ST_RECALL = 2'd0,
    ST_IDLE   = 2'd1,
    ST_ACTIVE = 2'd2,
    ST_STORE  = 2'd3
  } wstate_e;
endpackage

// File: rtl/wiper_rst_sync.sv
module wiper_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= 1'b1;
      s2_q <= s1_q;
    end
  end

  assign srst_n = s2_q;
endmodule

// File: rtl/wiper_sync.sv
module wiper_sync #(
  parameter int W = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);
  logic [W-1:0] m1_q, m2_q;

  // Two flops per input bit; the reset value is the idle level of each pin.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m1_q <= RST_VAL;
      m2_q <= RST_VAL;
    end else begin
      m1_q <= d_async;
      m2_q <= m1_q;
    end
  end

  assign q_sync = m2_q;
endmodule

// File: rtl/wiper_nvstore.sv
module wiper_nvstore #(
  parameter int CW           = 5,
  parameter int STORE_CYCLES = 20,
  parameter int NV_INIT      = 16
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] wdata,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] nv_val
);
  localparam int TW = $clog2(STORE_CYCLES + 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] pend_q, pend_d;
  logic [CW-1:0] nv_q;

  // Write-delay timer: loaded on start, then counts down to zero.
  always_comb begin
    cnt_d  = cnt_q;
    pend_d = pend_q;
    if (start) begin
      cnt_d  = TW'(STORE_CYCLES);
      pend_d = wdata;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == TW'(1));

  // The stored value is reset only at power-on, never by the soft reset.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      nv_q <= CW'(NV_INIT);
    end else if (done) begin
      nv_q <= pend_q;
    end
  end

  assign nv_val = nv_q;

  // R5
  nv_write_chk: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
    (nv_q != $past(nv_q)) |-> $past(busy));
endmodule

// File: rtl/wiper_decode.sv
module wiper_decode #(
  parameter int TAPS = 32,
  parameter int CW   = 5
) (
  input  logic [CW-1:0]   count,
  output logic [TAPS-1:0] tap_sel
);
  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    assign tap_sel[i] = (count == CW'(i));
  end
endmodule

// File: rtl/wiper_ctrl.sv
module wiper_ctrl #(
  parameter int TAPS         = 32,
  parameter int STORE_CYCLES = 20,
  parameter int NV_INIT      = 16
) (
  input  logic                     clk,
  input  logic                     por_n,
  input  logic                     rst_n,
  input  logic                     sel_n,
  input  logic                     dir_up,
  input  logic                     step_n,
  output logic [TAPS-1:0]          tap_sel,
  output logic [$clog2(TAPS)-1:0]  wiper_pos,
  output logic                     store_busy,
  output logic                     standby
);
  import wiper_pkg::*;

  localparam int CW = $clog2(TAPS);
  localparam logic [CW-1:0] MAXC = CW'(TAPS - 1);

  logic          irst_n;
  logic [2:0]    pins_s;
  logic          sel_s, step_s, dir_s;
  logic          sel_p_q, step_p_q;
  logic          sel_rise, step_fall;
  wstate_e       state_q, state_d;
  logic [CW-1:0] count_q, count_d;
  logic          store_go, store_done;
  logic [CW-1:0] nv_val;

  wiper_rst_sync u_rst (
    .clk    (clk),
    .arst_n (por_n & rst_n),
    .srst_n (irst_n)
  );

  // Pin order {sel_n, step_n, dir_up}; idle levels are 1, 1, 0.
  wiper_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
    .clk     (clk),
    .rst_n   (irst_n),
    .d_async ({sel_n, step_n, dir_up}),
    .q_sync  (pins_s)
  );

  assign sel_s  = pins_s[2];
  assign step_s = pins_s[1];
  assign dir_s  = pins_s[0];

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      sel_p_q  <= 1'b1;
      step_p_q <= 1'b1;
    end else begin
      sel_p_q  <= sel_s;
      step_p_q <= step_s;
    end
  end

  assign sel_rise  = sel_s & ~sel_p_q;
  assign step_fall = step_p_q & ~step_s;

  // Next-state and counter logic
  always_comb begin
    state_d  = state_q;
    count_d  = count_q;
    store_go = 1'b0;
    unique case (state_q)
      ST_RECALL: begin
        count_d = nv_val;
        state_d = ST_IDLE;
      end
      ST_IDLE: begin
        if (!sel_s) state_d = ST_ACTIVE;
      end
      ST_ACTIVE: begin
        if (sel_rise) begin
          if (step_s) begin
            store_go = 1'b1;
            state_d  = ST_STORE;
          end else begin
            state_d = ST_IDLE;
          end
        end else if (step_fall) begin
          if (dir_s) begin
            if (count_q != MAXC) count_d = count_q + 1'b1;
          end else begin
            if (count_q != '0) count_d = count_q - 1'b1;
          end
        end
      end
      ST_STORE: begin
        if (store_done) state_d = ST_IDLE;
      end
      default: state_d = ST_RECALL;
    endcase
  end

  always_ff @(posedge clk or negedge irst_n) begin
    if (!irst_n) begin
      state_q <= ST_RECALL;
      count_q <= '0;
    end else begin
      state_q <= state_d;
      count_q <= count_d;
    end
  end

  wiper_nvstore #(.CW(CW), .STORE_CYCLES(STORE_CYCLES), .NV_INIT(NV_INIT)) u_nv (
    .clk    (clk),
    .por_n  (por_n),
    .rst_n  (irst_n),
    .start  (store_go),
    .wdata  (count_q),
    .busy   (store_busy),
    .done   (store_done),
    .nv_val (nv_val)
  );

  wiper_decode #(.TAPS(TAPS), .CW(CW)) u_dec (
    .count   (count_q),
    .tap_sel (tap_sel)
  );

  assign wiper_pos = count_q;
  assign standby   = (state_q == ST_IDLE);

  // R1
  onehot_chk: assert property (@(posedge clk) disable iff (!irst_n)
    $onehot(tap_sel));
  // R4
  no_wrap_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (state_q == ST_ACTIVE) |=>
      !(($past(count_q) == MAXC && count_q == '0) ||
        ($past(count_q) == '0 && count_q == MAXC)));
  // R8
  store_hold_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (state_q == ST_STORE) |=> $stable(count_q));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!irst_n)
    (state_q == ST_IDLE) |=> $stable(count_q));
  // R7
  standby_excl_chk: assert property (@(posedge clk) disable iff (!irst_n)
    !(standby && store_busy));
endmodule

// File: tb/wiper_ctrl_tb.sv
`timescale 1ns/1ps
module wiper_ctrl_tb;
  localparam int TAPS = 32;
  localparam int SC   = 12;
  localparam int NVI  = 16;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic por_n, rst_n, sel_n, dir_up, step_n;
  logic [TAPS-1:0] tap_sel;
  logic [4:0]      wiper_pos;
  logic            store_busy, standby;

  wiper_ctrl #(.TAPS(TAPS), .STORE_CYCLES(SC), .NV_INIT(NVI)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .sel_n(sel_n), .dir_up(dir_up),
    .step_n(step_n), .tap_sel(tap_sel), .wiper_pos(wiper_pos),
    .store_busy(store_busy), .standby(standby)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cmp_on = 0;
  int fin = 0;
  int wd = 0;

  task automatic chk(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Reference model: modes 0 recall, 1 idle, 2 selected, 3 saving
  int m_rs1, m_rs2, m_s1sel, m_s2sel, m_psel, m_s1st, m_s2st, m_pst, m_s1d, m_s2d;
  int m_mode, m_count, m_cnt, m_pend, m_nv;

  always @(posedge clk) begin
    int eff, o_nv, rise, fall, go, nm, nc;
    eff  = (m_rs2 == 1 && por_n && rst_n) ? 1 : 0;
    o_nv = m_nv;
    if (!por_n) m_nv = NVI;
    else if (eff == 1 && m_cnt == 1) m_nv = m_pend;
    if (!(por_n && rst_n)) begin m_rs1 = 0; m_rs2 = 0; end
    else begin m_rs2 = m_rs1; m_rs1 = 1; end
    if (eff == 0) begin
      m_s1sel = 1; m_s2sel = 1; m_psel = 1;
      m_s1st = 1; m_s2st = 1; m_pst = 1;
      m_s1d = 0; m_s2d = 0;
      m_mode = 0; m_count = 0; m_cnt = 0; m_pend = 0;
    end else begin
      rise = (m_psel == 0 && m_s2sel == 1);
      fall = (m_pst == 1 && m_s2st == 0);
      go = 0; nm = m_mode; nc = m_count;
      case (m_mode)
        0: begin nc = o_nv; nm = 1; end
        1: if (m_s2sel == 0) nm = 2;
        2: begin
          if (rise) begin
            if (m_s2st == 1) begin go = 1; nm = 3; end else nm = 1;
          end else if (fall) begin
            if (m_s2d == 1) begin if (nc < TAPS - 1) nc++; end
            else begin if (nc > 0) nc--; end
          end
        end
        default: if (m_cnt == 1) nm = 1;
      endcase
      if (go == 1) begin m_cnt = SC; m_pend = m_count; end
      else if (m_cnt > 0) m_cnt--;
      m_psel = m_s2sel; m_s2sel = m_s1sel; m_s1sel = int'(sel_n);
      m_pst = m_s2st; m_s2st = m_s1st; m_s1st = int'(step_n);
      m_s2d = m_s1d; m_s1d = int'(dir_up);
      m_mode = nm; m_count = nc;
    end
  end

  // Per-cycle comparison, sampled 1 ns after the rising edge
  always @(posedge clk) begin
    #1;
    if (cmp_on == 1 && fin == 0) begin
      chk("R3 wiper_pos vs model", wiper_pos, m_count);
      chk("R1 tap_sel vs model", tap_sel, longint'(1) << m_count);
      chk("R5 store_busy vs model", store_busy, (m_cnt != 0) ? 1 : 0);
      chk("R7 standby vs model", standby, (m_mode == 1) ? 1 : 0);
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 50000 && fin == 0) begin
      fin = 1;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 50000);
      report();
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic step(input logic up);
    dir_up = up; tick(1);
    step_n = 1'b0; tick(4);
    step_n = 1'b1; tick(4);
  endtask

  task automatic soft_reset();
    rst_n = 1'b0; tick(2);
    rst_n = 1'b1; tick(5);
  endtask

  initial begin
    int busy_n;
    por_n = 1'b0; rst_n = 1'b1; sel_n = 1'b1; dir_up = 1'b0; step_n = 1'b1;
    tick(3);
    cmp_on = 1;
    por_n = 1'b1; tick(5);
    chk("R10 power-on recall", wiper_pos, NVI);
    chk("R7 standby after recall", standby, 1);

    sel_n = 1'b0; tick(4);
    chk("R7 standby drops when selected", standby, 0);
    // R11 latency: count moves on the third rising edge after the fall
    dir_up = 1'b1; tick(1);
    step_n = 1'b0; tick(2);
    chk("R11 no change after two edges", wiper_pos, NVI);
    tick(1);
    chk("R11 change at third edge", wiper_pos, NVI + 1);
    step_n = 1'b1; tick(3);
    step(1); step(1);
    chk("R3 up steps", wiper_pos, NVI + 3);
    for (int i = 0; i < 4; i++) step(0);
    chk("R3 down steps", wiper_pos, NVI - 1);
    chk("R1 tap position", tap_sel, longint'(1) << (NVI - 1));

    for (int i = 0; i < 20; i++) step(1);
    chk("R4 saturate high", wiper_pos, 31);
    chk("R1 top tap", tap_sel, longint'(1) << 31);
    for (int i = 0; i < 34; i++) step(0);
    chk("R4 saturate low", wiper_pos, 0);
    for (int i = 0; i < 5; i++) step(1);

    // R5: save with step_n high
    sel_n = 1'b1;
    busy_n = 0;
    for (int i = 0; i < SC + 12; i++) begin
      tick(1);
      if (store_busy) busy_n++;
    end
    chk("R5 busy length", busy_n, SC);
    chk("R7 standby after save", standby, 1);

    // R2: strobes while deselected
    dir_up = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step_n = 1'b0; tick(4); step_n = 1'b1; tick(4);
    end
    chk("R2 deselected strobes ignored", wiper_pos, 5);

    soft_reset();
    chk("R9 recall of saved value", wiper_pos, 5);

    // R6: select rise and step fall in the same cycle -> abort, no move
    sel_n = 1'b0; tick(4);
    for (int i = 0; i < 4; i++) step(1);
    chk("R3 before abort", wiper_pos, 9);
    step_n = 1'b0; sel_n = 1'b1; tick(6);
    chk("R6 tie does not move", wiper_pos, 9);
    chk("R6 standby after abort", standby, 1);
    chk("R6 no busy on abort", store_busy, 0);
    step_n = 1'b1; tick(3);
    soft_reset();
    chk("R6 stored value unchanged", wiper_pos, 5);

    // R8: strobes during the save window
    sel_n = 1'b0; tick(4);
    step(1); step(1);
    sel_n = 1'b1; tick(4);
    chk("R8 busy seen", store_busy, 1);
    sel_n = 1'b0; dir_up = 1'b1;
    step_n = 1'b0; tick(3); step_n = 1'b1; tick(3);
    tick(10);
    chk("R8 count held through save", wiper_pos, 7);
    soft_reset();
    chk("R9 recall after second save", wiper_pos, 7);

    por_n = 1'b0; tick(2);
    por_n = 1'b1; tick(5);
    chk("R10 power-on reinitialises", wiper_pos, NVI);

    fin = 1;
    report();
  end
endmodule